// File: doc/BRIEF.md
# ADC Power Sequencing Controller

This block owns the power lifecycle of an analog-to-digital converter core. Software requests power-up, power-down, conversion start and conversion abort through single-cycle request strobes. The block answers with readback bits that hardware clears once each request has been served. It drives a power signal and a conversion-launch pulse to the analog core, and it takes a completion pulse back from the core. A sticky ready flag, which software clears by writing 1, tells software when the powered core has settled. A maskable interrupt output follows the ready flag.

Time inside the block is measured in converter clock periods. These arrive as a single-cycle enable pulse on the bus clock, so the block has no second clock domain. Two rules apply to those periods. The core must settle for a configured number of them before it is usable. A power-down request is not acted on until a minimum number of them have passed since power-up was requested. In auto-off mode the core stays unpowered while the block is enabled and idle. The block then powers the core up for each conversion and drops power again when the conversion ends, and the ready flag stays clear throughout.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, every output is 0.
- R2: A pulse on `req_enable` while off sets `en_bit` and raises `core_pwr` at the next clock edge. `rdy_flag` stays 0 until `STARTUP_CYC` `adc_ce` pulses have been seen after that edge, and it rises at the clock edge after the last of them.
- R3: `rdy_flag` holds its value until a cycle with `rdy_clr` high, which clears it. Cycles with `rdy_clr` low leave it unchanged.
- R4: `rdy_irq` is high exactly when `rdy_flag` and `cfg_rdy_ie` are both 1.
- R5: `req_start` while ready sets `start_bit` and produces a single-cycle `core_go` while `core_pwr` is 1. `start_bit` returns to 0 at the edge after `core_done`, and the core stays powered.
- R6: With `cfg_trig_en` at 0, `ext_trig` starts nothing. With `cfg_trig_en` at 1, `ext_trig` starts a conversion exactly as `req_start` does.
- R7: `req_stop` during a conversion sets `stop_bit`, which also drives `core_abort`. At the first clock edge after that at which `adc_ce` is 1, both `stop_bit` and `start_bit` return to 0.
- R8: `req_disable` while `start_bit` is 1 is ignored: `dis_bit` stays 0 and the conversion completes.
- R9: After `req_disable`, `core_pwr` stays 1 until `MIN_GAP` `adc_ce` pulses have passed since the edge that set `en_bit`. Power drops at the next edge after that, provided no conversion is running.
- R10: Once power-down has started, `core_pwr` is 0. After `SHUTDOWN_CYC` further `adc_ce` pulses, `en_bit` and `dis_bit` clear together at the next edge.
- R11: `req_disable` while off (`en_bit` 0) is ignored: `dis_bit` stays 0.
- R12: `req_enable` during power-down is held. When power-down completes, `en_bit` stays 1 and the startup sequence begins at once, ending with `rdy_flag` set.
- R13: With `cfg_auto_off` at 1, enabling leaves `core_pwr` at 0. A start powers the core, waits `STARTUP_CYC` `adc_ce` pulses, then issues `core_go`. Power drops at the edge after `core_done`, and `rdy_flag` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_ce | input | 1 | One pulse per converter clock period |
| req_enable | input | 1 | Power-up request strobe |
| req_disable | input | 1 | Power-down request strobe |
| req_start | input | 1 | Conversion start strobe |
| req_stop | input | 1 | Conversion abort strobe |
| rdy_clr | input | 1 | Write-1 clear of the ready flag |
| cfg_auto_off | input | 1 | Automatic power-off per conversion |
| cfg_rdy_ie | input | 1 | Ready interrupt enable |
| cfg_trig_en | input | 1 | Allow external trigger to start conversions |
| ext_trig | input | 1 | External trigger pulse |
| core_done | input | 1 | Conversion complete pulse from core |
| en_bit | output | 1 | Enable readback, cleared when power-down completes |
| dis_bit | output | 1 | Disable readback, pending or in progress |
| start_bit | output | 1 | Conversion in progress |
| stop_bit | output | 1 | Abort pending |
| rdy_flag | output | 1 | Core settled and ready |
| rdy_irq | output | 1 | Ready interrupt |
| core_pwr | output | 1 | Power/enable to analog core |
| core_go | output | 1 | Conversion launch pulse |
| core_abort | output | 1 | Abort request to core |

## Verification
The bench builds the block with `STARTUP_CYC` 4, `MIN_GAP` 10 and `SHUTDOWN_CYC` 3, and it pulses `adc_ce` on every third bus cycle. With those values the startup completes well inside the ten-pulse spacing window. A disable issued right after ready is therefore visibly held back, so the spacing rule becomes observable. The short shutdown also lets an enable land inside the power-down window, which exercises the deferred restart.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_WAKE,
    PS_READY,
    PS_CONV,
    PS_ARMED,
    PS_DOWN
  } pwr_state_e;

  localparam int unsigned TMR_WAKE = 0;
  localparam int unsigned TMR_GAP  = 1;
  localparam int unsigned TMR_DOWN = 2;
  localparam int unsigned TMR_NUM  = 3;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_pwr_rst_sync.sv
module adc_pwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (ce && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_flag.sv
module adc_pwr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic auto_off,
  input  logic irq_en,
  output logic rdy,
  output logic irq
);
  logic rdy_q, rdy_d;

  always_comb begin
    rdy_d = rdy_q;
    if (set && !auto_off) rdy_d = 1'b1;
    else if (clr)         rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign rdy = rdy_q;
  assign irq = rdy_q & irq_en;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               en_set,
  input  logic               dis_set,
  input  logic               stop_set,
  input  logic               trig,
  input  logic               auto_off,
  input  logic               conv_done,
  input  logic [TMR_NUM-1:0] tmr_exp,
  output logic [TMR_NUM-1:0] tmr_load,
  output logic               rdy_set,
  output pwr_state_e         state,
  output logic               en_q,
  output logic               dis_q,
  output logic               start_q,
  output logic               stop_q,
  output logic               go_q
);
  pwr_state_e st_q, st_d;
  logic en_d, dis_d, start_d, stop_d, pend_q, pend_d, go_d;
  logic abort;

  assign abort = start_q & stop_q & ce;

  always_comb begin
    st_d     = st_q;
    en_d     = en_q;
    dis_d    = dis_q;
    start_d  = start_q;
    stop_d   = stop_q;
    pend_d   = pend_q;
    go_d     = 1'b0;
    tmr_load = '0;
    rdy_set  = 1'b0;
    unique case (st_q)
      PS_OFF: begin
        if (en_set) begin
          en_d = 1'b1;
          tmr_load[TMR_GAP] = 1'b1;
          if (auto_off) begin
            st_d = PS_ARMED;
          end else begin
            st_d = PS_WAKE;
            tmr_load[TMR_WAKE] = 1'b1;
          end
        end
      end
      PS_WAKE: begin
        if (dis_set && !start_q) dis_d = 1'b1;
        if (abort) begin
          start_d = 1'b0;
          stop_d  = 1'b0;
          st_d    = PS_ARMED;
        end else if (dis_q && tmr_exp[TMR_GAP] && !start_q) begin
          st_d = PS_DOWN;
          tmr_load[TMR_DOWN] = 1'b1;
        end else if (tmr_exp[TMR_WAKE]) begin
          if (start_q) begin
            st_d = PS_CONV;
            go_d = 1'b1;
          end else begin
            st_d    = PS_READY;
            rdy_set = 1'b1;
          end
        end else if (stop_set && start_q) begin
          stop_d = 1'b1;
        end
      end
      PS_READY: begin
        if (dis_set) dis_d = 1'b1;
        if (dis_q && tmr_exp[TMR_GAP]) begin
          st_d = PS_DOWN;
          tmr_load[TMR_DOWN] = 1'b1;
        end else if (trig && !dis_q && !dis_set) begin
          st_d    = PS_CONV;
          start_d = 1'b1;
          go_d    = 1'b1;
        end
      end
      PS_ARMED: begin
        if (dis_set) dis_d = 1'b1;
        if (dis_q && tmr_exp[TMR_GAP]) begin
          st_d = PS_DOWN;
          tmr_load[TMR_DOWN] = 1'b1;
        end else if (trig && !dis_q && !dis_set) begin
          st_d    = PS_WAKE;
          start_d = 1'b1;
          tmr_load[TMR_WAKE] = 1'b1;
        end
      end
      PS_CONV: begin
        if (abort || conv_done) begin
          start_d = 1'b0;
          stop_d  = 1'b0;
          st_d    = auto_off ? PS_ARMED : PS_READY;
        end else if (stop_set) begin
          stop_d = 1'b1;
        end
      end
      PS_DOWN: begin
        if (en_set) pend_d = 1'b1;
        if (tmr_exp[TMR_DOWN]) begin
          dis_d  = 1'b0;
          pend_d = 1'b0;
          if (pend_q || en_set) begin
            tmr_load[TMR_GAP] = 1'b1;
            if (auto_off) begin
              st_d = PS_ARMED;
            end else begin
              st_d = PS_WAKE;
              tmr_load[TMR_WAKE] = 1'b1;
            end
          end else begin
            en_d = 1'b0;
            st_d = PS_OFF;
          end
        end
      end
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_OFF;
      en_q    <= 1'b0;
      dis_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      pend_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      en_q    <= en_d;
      dis_q   <= dis_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      pend_q  <= pend_d;
      go_q    <= go_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int unsigned STARTUP_CYC  = 16,
  parameter int unsigned MIN_GAP      = 10,
  parameter int unsigned SHUTDOWN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_ce,
  input  logic req_enable,
  input  logic req_disable,
  input  logic req_start,
  input  logic req_stop,
  input  logic rdy_clr,
  input  logic cfg_auto_off,
  input  logic cfg_rdy_ie,
  input  logic cfg_trig_en,
  input  logic ext_trig,
  input  logic core_done,
  output logic en_bit,
  output logic dis_bit,
  output logic start_bit,
  output logic stop_bit,
  output logic rdy_flag,
  output logic rdy_irq,
  output logic core_pwr,
  output logic core_go,
  output logic core_abort
);
  localparam int unsigned MAX_CNT = max3(STARTUP_CYC, MIN_GAP, SHUTDOWN_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [TMR_NUM*CNT_W-1:0] TMR_VAL =
    {CNT_W'(SHUTDOWN_CYC), CNT_W'(MIN_GAP), CNT_W'(STARTUP_CYC)};

  logic               rst_n_int;
  logic [TMR_NUM-1:0] tmr_load, tmr_exp;
  logic               rdy_set, trig;
  pwr_state_e         state;

  adc_pwr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
    adc_pwr_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .ce       (adc_ce),
      .load     (tmr_load[g]),
      .load_val (TMR_VAL[g*CNT_W +: CNT_W]),
      .expired  (tmr_exp[g])
    );
  end

  assign trig = req_start | (cfg_trig_en & ext_trig);

  adc_pwr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ce        (adc_ce),
    .en_set    (req_enable),
    .dis_set   (req_disable),
    .stop_set  (req_stop),
    .trig      (trig),
    .auto_off  (cfg_auto_off),
    .conv_done (core_done),
    .tmr_exp   (tmr_exp),
    .tmr_load  (tmr_load),
    .rdy_set   (rdy_set),
    .state     (state),
    .en_q      (en_bit),
    .dis_q     (dis_bit),
    .start_q   (start_bit),
    .stop_q    (stop_bit),
    .go_q      (core_go)
  );

  adc_pwr_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set      (rdy_set),
    .clr      (rdy_clr),
    .auto_off (cfg_auto_off),
    .irq_en   (cfg_rdy_ie),
    .rdy      (rdy_flag),
    .irq      (rdy_irq)
  );

  assign core_pwr   = (state == PS_WAKE) || (state == PS_READY) || (state == PS_CONV);
  assign core_abort = stop_bit;
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk #(
  parameter int unsigned MIN_GAP = 10
) (
  input logic clk,
  input logic rst_n,
  input logic adc_ce,
  input logic req_disable,
  input logic rdy_clr,
  input logic cfg_auto_off,
  input logic en_bit,
  input logic dis_bit,
  input logic start_bit,
  input logic stop_bit,
  input logic rdy_flag,
  input logic core_pwr,
  input logic core_go
);
  localparam int unsigned GW = $clog2(MIN_GAP + 1) + 1;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                gap_cnt <= '0;
    else if (!en_bit)                          gap_cnt <= '0;
    else if (adc_ce && gap_cnt < GW'(MIN_GAP)) gap_cnt <= gap_cnt + 1'b1;
  end

  AST_RDY_WITH_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_flag) |-> core_pwr); // R2
  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_flag && !rdy_clr) |=> rdy_flag); // R3
  AST_GO_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |-> (core_pwr && start_bit)); // R5
  AST_STOP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_bit && adc_ce) |=> (!stop_bit && !start_bit)); // R7
  AST_CONV_DIS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && !dis_bit && req_disable) |=> !dis_bit); // R8
  AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_bit && $fell(core_pwr)) |-> (gap_cnt >= GW'(MIN_GAP))); // R9
  AST_OFF_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_bit) |-> !core_pwr); // R10
  AST_OFF_DIS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit && !dis_bit && req_disable) |=> !dis_bit); // R11
  AST_AUTO_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_off && !rdy_flag) |=> !rdy_flag); // R13
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk #(.MIN_GAP(MIN_GAP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adc_ce       (adc_ce),
  .req_disable  (req_disable),
  .rdy_clr      (rdy_clr),
  .cfg_auto_off (cfg_auto_off),
  .en_bit       (en_bit),
  .dis_bit      (dis_bit),
  .start_bit    (start_bit),
  .stop_bit     (stop_bit),
  .rdy_flag     (rdy_flag),
  .core_pwr     (core_pwr),
  .core_go      (core_go)
);

// File: tb/adc_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module adc_pwr_ctrl_bench;
  localparam int unsigned STARTUP = 4;
  localparam int unsigned GAP     = 10;
  localparam int unsigned SHUT    = 3;
  localparam int          CONV_LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_ce = 1'b0;
  logic req_enable = 1'b0, req_disable = 1'b0, req_start = 1'b0, req_stop = 1'b0;
  logic rdy_clr = 1'b0, cfg_auto_off = 1'b0, cfg_rdy_ie = 1'b0, cfg_trig_en = 1'b0;
  logic ext_trig = 1'b0, core_done = 1'b0;
  logic en_bit, dis_bit, start_bit, stop_bit, rdy_flag, rdy_irq;
  logic core_pwr, core_go, core_abort;

  int checks = 0;
  int errors = 0;
  int ce_seen = 0;
  int stub_cnt = 0;
  logic [1:0] div = 2'd0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  adc_pwr_ctrl #(.STARTUP_CYC(STARTUP), .MIN_GAP(GAP), .SHUTDOWN_CYC(SHUT)) u_adc_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_ce(adc_ce),
    .req_enable(req_enable), .req_disable(req_disable), .req_start(req_start),
    .req_stop(req_stop), .rdy_clr(rdy_clr), .cfg_auto_off(cfg_auto_off),
    .cfg_rdy_ie(cfg_rdy_ie), .cfg_trig_en(cfg_trig_en), .ext_trig(ext_trig),
    .core_done(core_done), .en_bit(en_bit), .dis_bit(dis_bit), .start_bit(start_bit),
    .stop_bit(stop_bit), .rdy_flag(rdy_flag), .rdy_irq(rdy_irq), .core_pwr(core_pwr),
    .core_go(core_go), .core_abort(core_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // converter clock: one pulse every third bus cycle
  always @(negedge clk) begin
    div    <= (div == 2'd2) ? 2'd0 : div + 2'd1;
    adc_ce <= (div == 2'd2);
  end

  always @(posedge clk) if (adc_ce) ce_seen <= ce_seen + 1;

  // analog core stub
  always @(negedge clk) begin
    core_done = 1'b0;
    if (core_go) stub_cnt = CONV_LAT;
    else if (stub_cnt > 0) begin
      if (core_abort) stub_cnt = 0;
      else begin
        stub_cnt = stub_cnt - 1;
        if (stub_cnt == 0) core_done = 1'b1;
      end
    end
  end

  // scoreboard monitor: every launch must match an expected item
  always @(negedge clk) begin
    if (rst_n && core_go) begin
      if (exp_q.size() == 0) chk("R5 unexpected core_go", 1, 0);
      else begin
        bit exp_auto;
        exp_auto = exp_q.pop_front();
        chk("R5 launch mode", cfg_auto_off, exp_auto);
        chk("R5 launch powered", core_pwr, 1);
      end
    end
  end

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: req_enable = 1'b1;
      1: req_disable = 1'b1;
      2: req_start = 1'b1;
      3: req_stop = 1'b1;
      4: rdy_clr = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    @(negedge clk);
    req_enable = 1'b0; req_disable = 1'b0; req_start = 1'b0;
    req_stop = 1'b0; rdy_clr = 1'b0; ext_trig = 1'b0;
  endtask

  task automatic launch(input int which);
    exp_q.push_back(cfg_auto_off);
    strobe(which);
  endtask

  task automatic wait_ce_from(input int base, input int n);
    while (ce_seen - base < n) @(negedge clk);
  endtask

  task automatic wait_conv_end();
    while (start_bit) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    int base;
    bit en_dropped;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset outputs", {en_bit, dis_bit, start_bit, stop_bit, rdy_flag, rdy_irq,
                              core_pwr, core_go, core_abort}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {en_bit, dis_bit, start_bit, rdy_flag, core_pwr, core_go}, 0);

    // R11: disable while off
    strobe(1);
    @(negedge clk);
    chk("R11 dis_bit while off", dis_bit, 0);
    chk("R11 power while off", core_pwr, 0);

    // R2: power up and stabilisation
    strobe(0);
    base = ce_seen;
    chk("R2 en_bit set", en_bit, 1);
    chk("R2 core powered", core_pwr, 1);
    wait_ce_from(base, STARTUP);
    chk("R2 not ready before startup end", rdy_flag, 0);
    @(posedge clk); #1;
    chk("R2 ready after startup", rdy_flag, 1);

    // R3 / R4
    repeat (5) @(negedge clk);
    chk("R3 holds without clear", rdy_flag, 1);
    chk("R4 irq masked", rdy_irq, 0);
    cfg_rdy_ie = 1'b1; #1;
    chk("R4 irq enabled", rdy_irq, 1);
    strobe(4);
    chk("R3 cleared by write 1", rdy_flag, 0);
    chk("R4 irq after clear", rdy_irq, 0);

    // R5: software start
    launch(2);
    chk("R5 start_bit set", start_bit, 1);
    wait_conv_end();
    chk("R5 powered after done", core_pwr, 1);
    chk("R5 start clears", start_bit, 0);

    // R6: external trigger gating
    strobe(5);
    repeat (2) @(negedge clk);
    chk("R6 trigger ignored when off", start_bit, 0);
    cfg_trig_en = 1'b1;
    launch(5);
    chk("R6 trigger starts", start_bit, 1);
    wait_conv_end();
    cfg_trig_en = 1'b0;

    // R8: disable during conversion
    launch(2);
    strobe(1);
    chk("R8 dis_bit ignored", dis_bit, 0);
    wait_conv_end();
    chk("R8 still powered", core_pwr, 1);
    chk("R8 still enabled", en_bit, 1);

    // R7: abort
    exp_q.push_back(cfg_auto_off);
    strobe(2);
    strobe(3);
    chk("R7 stop pending", stop_bit, 1);
    chk("R7 abort to core", core_abort, 1);
    base = ce_seen;
    wait_ce_from(base, 1);
    chk("R7 stop cleared", stop_bit, 0);
    chk("R7 start cleared", start_bit, 0);

    // R10: plain disable (spacing long met)
    strobe(1);
    chk("R10 dis_bit set", dis_bit, 1);
    @(posedge clk); #1;
    chk("R10 power dropped", core_pwr, 0);
    base = ce_seen;
    wait_ce_from(base, SHUT);
    chk("R10 enable held during shutdown", en_bit, 1);
    @(posedge clk); #1;
    chk("R10 bits cleared", {en_bit, dis_bit}, 2'b00);

    // R9: spacing between enable and disable
    strobe(4);
    strobe(0);
    base = ce_seen;
    while (!rdy_flag) @(negedge clk);
    strobe(1);
    chk("R9 disable pending", dis_bit, 1);
    wait_ce_from(base, GAP);
    chk("R9 power held until spacing", core_pwr, 1);
    @(posedge clk); #1;
    chk("R9 power drops after spacing", core_pwr, 0);

    // R12: enable during power-down deferred
    base = ce_seen;
    strobe(4);
    strobe(0);
    en_dropped = 1'b0;
    while (ce_seen - base < SHUT) begin
      if (!en_bit) en_dropped = 1'b1;
      @(negedge clk);
    end
    @(posedge clk); #1;
    chk("R12 enable never dropped", en_dropped || !en_bit, 0);
    chk("R12 restart powered", core_pwr, 1);
    chk("R12 disable cleared", dis_bit, 0);
    chk("R12 not yet ready", rdy_flag, 0);
    base = ce_seen;
    wait_ce_from(base, STARTUP);
    @(posedge clk); #1;
    chk("R12 ready after restart", rdy_flag, 1);

    // R13: auto-off
    strobe(1);
    while (en_bit) @(negedge clk);
    strobe(4);
    cfg_auto_off = 1'b1;
    strobe(0);
    chk("R13 enabled", en_bit, 1);
    chk("R13 unpowered while idle", core_pwr, 0);
    launch(2);
    chk("R13 powered for conversion", core_pwr, 1);
    wait_conv_end();
    chk("R13 power off after conversion", core_pwr, 0);
    chk("R13 ready never set", rdy_flag, 0);
    chk("R13 no interrupt", rdy_irq, 0);
    chk("R13 still enabled", en_bit, 1);

    repeat (4) @(negedge clk);
    chk("R5 all launches seen", exp_q.size(), 0);
    summary();
  end
endmodule